// File: doc/BRIEF.md
# Pseudo-static RAM power-down mode unlock sequencer

This block sits inside a behavioural pseudo-static RAM model. It watches every read and write cycle on the 22-bit address bus. The low-power mode register can only be reached through a fixed six-access pattern aimed at the highest address:

1. A read whose returned value is remembered.
2. Two write-backs of that value.
3. Two dummy writes.
4. A final read whose address acts as the mode key.

A completed pattern loads the selected mode and raises a one-cycle apply pulse. Any access that leaves the pattern cancels it. Whether the breaking write still reaches the array depends on the stage at which the pattern broke.

The array is a small register file. Its index is made of the top `HI_W` and bottom `LO_W` address bits, so addresses that share those bits alias to one entry. The `powerOn` input models the chip-enable power-down pin. While it is low, accesses are ignored and the array is erased according to the selected mode:

- Sleep erases every entry.
- A partial mode keeps only the lowest 1/16, 1/8 or 1/4 of the address space and erases the rest.

Between accesses the host must raise `standby`.

Top module: `psram_pd_unlock`

## Requirements
- R1: After reset `pdMode` is 0 (Sleep), `modeApply` is low and `rdData` is 0. No programming is needed to be in Sleep.
- R2: A write strobe stores `wrData` at `addr`. A read strobe returns the stored word on `rdData` one clock after the strobe. The word is captured at the strobe edge.
- R3: The full pattern loads `pdMode` and pulses `modeApply` high for exactly one cycle, in the cycle after the final read. The pattern is: read 3FFFFFh; write 3FFFFFh with the read value, twice; write 3FFFFFh with any data, twice; read the key. The key encodings are 3FFFFFh→0 (Sleep), 37FFFFh→1 (1/16 kept), 2FFFFFh→2 (1/8 kept) and 27FFFFh→3 (1/4 kept). `pdMode` changes at no other time.
- R4: A write in step 2 or 3 that targets another address, or carries data different from the step-1 value, cancels the pattern. That write is performed normally.
- R5: Writes in steps 4 and 5 never reach the array. If such a write goes to another address, the pattern is cancelled and that write is discarded.
- R6: A step-6 read of a non-key address cancels the pattern without a mode change or pulse. The read returns array data normally.
- R7: A read in steps 2 to 5, or a write in step 6, cancels the pattern, and the access is performed normally. A read of 3FFFFFh that breaks the pattern starts a new step 1.
- R8: An access strobe with no `standby` cycle since the previous access cancels an ongoing pattern.
- R9: While `powerOn` is low, strobes are ignored and the pattern resets. Sleep erases the whole array to 0. A partial mode keeps the entries whose top four address bits are below 1, 2 or 4 (modes 1, 2 and 3) and erases the rest. The mode is kept across power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOn | input | 1 | Low forces power-down in the selected mode |
| standby | input | 1 | High in idle cycles between accesses |
| cycStb | input | 1 | One-cycle access strobe |
| isWrite | input | 1 | 1 = write access, 0 = read access |
| addr | input | 22 | Access address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid one cycle after a read strobe |
| pdMode | output | 2 | Selected power-down mode (encoding in R3) |
| modeApply | output | 1 | One-cycle pulse when a new mode is loaded |

## Verification
The bench breaks the pattern at every stage: a wrong address in the write-back steps, wrong data in the write-back steps, a stray address in the dummy steps, a bad key, a restart read and a write in the key step. After each break it checks the array contents. A design that mixed up write-back cancellation with dummy cancellation would either lose the aborted write-back or corrupt the array with dummy data.

It also omits a standby gap and confirms that no mode is loaded. It powers down under a partial mode while issuing a write. A design that decoded the retained range wrongly, or accepted strobes while powered down, would leave wrong words behind after wake-up.

// File: rtl/psram_pd_pkg.sv
package psram_pd_pkg;

  typedef enum logic [1:0] {
    PD_SLEEP   = 2'd0,
    PD_KEEP4M  = 2'd1,
    PD_KEEP8M  = 2'd2,
    PD_KEEP16M = 2'd3
  } pdMode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_GOT1 = 3'd1,
    SEQ_GOT2 = 3'd2,
    SEQ_GOT3 = 3'd3,
    SEQ_GOT4 = 3'd4,
    SEQ_GOT5 = 3'd5
  } seqState_e;

  typedef struct packed {
    logic readEn;
    logic writeEn;
    logic captureRda;
  } dpCtl_t;

endpackage

// File: rtl/psram_pd_datapath.sv
module psram_pd_datapath
  import psram_pd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int HI_W   = 4,
  parameter int LO_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOn,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  pdMode_e           pdMode,
  output logic [DATA_W-1:0] rdData,
  output logic              topHit,
  output logic              dataMatch,
  output logic              keyHit,
  output pdMode_e           keyMode
);

  localparam int IDX_W = HI_W + LO_W;
  localparam int DEPTH = 1 << IDX_W;

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] KEY_4M   = TOP_ADDR & ~(ADDR_W'(1) << (ADDR_W-3));
  localparam logic [ADDR_W-1:0] KEY_8M   = TOP_ADDR & ~(ADDR_W'(1) << (ADDR_W-2));
  localparam logic [ADDR_W-1:0] KEY_16M  = KEY_4M & KEY_8M;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdaReg;
  logic [IDX_W-1:0]  idx;

  assign idx       = {addr[ADDR_W-1 -: HI_W], addr[LO_W-1:0]};
  assign topHit    = (addr == TOP_ADDR);
  assign dataMatch = (wrData == rdaReg);

  always_comb begin
    keyHit  = 1'b1;
    keyMode = PD_SLEEP;
    if (addr == TOP_ADDR)      keyMode = PD_SLEEP;
    else if (addr == KEY_4M)   keyMode = PD_KEEP4M;
    else if (addr == KEY_8M)   keyMode = PD_KEEP8M;
    else if (addr == KEY_16M)  keyMode = PD_KEEP16M;
    else                       keyHit  = 1'b0;
  end

  // Whether an entry survives power-down in the given mode
  function automatic logic keepEntry(input int unsigned ent, input pdMode_e m);
    int unsigned hi;
    hi = ent >> LO_W;
    case (m)
      PD_KEEP4M:  return hi < 1;
      PD_KEEP8M:  return hi < 2;
      PD_KEEP16M: return hi < 4;
      default:    return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData <= '0;
      rdaReg <= '0;
    end else if (!powerOn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!keepEntry(i, pdMode)) mem[i] <= '0;
      end
    end else begin
      if (ctl.writeEn)    mem[idx] <= wrData;
      if (ctl.readEn)     rdData   <= mem[idx];
      if (ctl.captureRda) rdaReg   <= mem[idx];
    end
  end

  // Step-1 capture and returned read data must agree
  assert_capture_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureRda |=> (rdaReg == rdData));

endmodule

// File: rtl/psram_pd_ctrl.sv
module psram_pd_ctrl
  import psram_pd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerOn,
  input  logic    standby,
  input  logic    cycStb,
  input  logic    isWrite,
  input  logic    topHit,
  input  logic    dataMatch,
  input  logic    keyHit,
  input  pdMode_e keyMode,
  output dpCtl_t  ctl,
  output pdMode_e pdMode,
  output logic    modeApply
);

  seqState_e state, nextState;
  logic sawIdle, applyNow, acc, gapOk, restart;

  assign acc     = cycStb && powerOn;
  assign gapOk   = sawIdle;
  assign restart = !isWrite && topHit;

  always_comb begin
    nextState = state;
    ctl       = '0;
    applyNow  = 1'b0;
    if (acc) begin
      ctl.readEn  = !isWrite;
      ctl.writeEn = isWrite;
      case (state)
        SEQ_IDLE: ;
        SEQ_GOT1, SEQ_GOT2: begin
          if (isWrite && topHit && dataMatch && gapOk)
            nextState = (state == SEQ_GOT1) ? SEQ_GOT2 : SEQ_GOT3;
          else
            nextState = SEQ_IDLE;
        end
        SEQ_GOT3, SEQ_GOT4: begin
          if (isWrite) ctl.writeEn = 1'b0;
          if (isWrite && topHit && gapOk)
            nextState = (state == SEQ_GOT3) ? SEQ_GOT4 : SEQ_GOT5;
          else
            nextState = SEQ_IDLE;
        end
        SEQ_GOT5: begin
          if (!isWrite && keyHit && gapOk) applyNow = 1'b1;
          nextState = SEQ_IDLE;
        end
        default: nextState = SEQ_IDLE;
      endcase
      if (nextState == SEQ_IDLE && restart && !applyNow) begin
        nextState      = SEQ_GOT1;
        ctl.captureRda = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      sawIdle   <= 1'b1;
      pdMode    <= PD_SLEEP;
      modeApply <= 1'b0;
    end else begin
      if (cycStb)       sawIdle <= 1'b0;
      else if (standby) sawIdle <= 1'b1;
      state     <= powerOn ? nextState : SEQ_IDLE;
      modeApply <= applyNow;
      if (applyNow) pdMode <= keyMode;
    end
  end

  assert_apply_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeApply |=> !modeApply);

  assert_mode_only_on_apply_R3: assert property (@(posedge clk) disable iff (!rstN)
    !modeApply |-> $stable(pdMode));

  assert_apply_from_key_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeApply |-> $past(cycStb && !isWrite && keyHit));

  assert_down_resets_seq_R9: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> (state == SEQ_IDLE));

endmodule

// File: rtl/psram_pd_unlock.sv
module psram_pd_unlock
  import psram_pd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int HI_W   = 4,
  parameter int LO_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOn,
  input  logic              standby,
  input  logic              cycStb,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        pdMode,
  output logic              modeApply
);

  dpCtl_t  ctl;
  pdMode_e modeQ, keyMode;
  logic    topHit, dataMatch, keyHit;

  psram_pd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerOn   (powerOn),
    .standby   (standby),
    .cycStb    (cycStb),
    .isWrite   (isWrite),
    .topHit    (topHit),
    .dataMatch (dataMatch),
    .keyHit    (keyHit),
    .keyMode   (keyMode),
    .ctl       (ctl),
    .pdMode    (modeQ),
    .modeApply (modeApply)
  );

  psram_pd_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HI_W   (HI_W),
    .LO_W   (LO_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .powerOn   (powerOn),
    .ctl       (ctl),
    .addr      (addr),
    .wrData    (wrData),
    .pdMode    (modeQ),
    .rdData    (rdData),
    .topHit    (topHit),
    .dataMatch (dataMatch),
    .keyHit    (keyHit),
    .keyMode   (keyMode)
  );

  assign pdMode = modeQ;

endmodule

// File: tb/psram_pd_unlock_bench.sv
module psram_pd_unlock_bench;

  localparam logic [21:0] TOP = 22'h3FFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerOn = 1'b1;
  logic        standby = 1'b1;
  logic        cycStb = 1'b0;
  logic        isWrite = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  pdMode;
  logic        modeApply;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] lastRd;
  logic        lastApply;
  logic [15:0] topVal;
  logic [15:0] rda;
  logic        applied;

  always #10 clk = ~clk;

  psram_pd_unlock u_psram_pd_unlock (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .standby(standby),
    .cycStb(cycStb), .isWrite(isWrite), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pdMode(pdMode), .modeApply(modeApply)
  );

  // {isWrite, addr, data}; for reads data is the expected value
  localparam logic [38:0] VEC [12] = '{
    {1'b1, 22'h000001, 16'h0101},
    {1'b1, 22'h040001, 16'h0202},
    {1'b1, 22'h080001, 16'h0303},
    {1'b1, 22'h0C0001, 16'h0404},
    {1'b1, 22'h200001, 16'h0808},
    {1'b1, 22'h000003, 16'h0033},
    {1'b1, 22'h100003, 16'h1111},
    {1'b1, 22'h3FFFFF, 16'hA5A5},
    {1'b0, 22'h000001, 16'h0101},
    {1'b0, 22'h200001, 16'h0808},
    {1'b0, 22'h3FFFFF, 16'hA5A5},
    {1'b0, 22'h100003, 16'h1111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [21:0] a, input logic [15:0] d, input bit idle);
    @(negedge clk);
    cycStb = 1'b1; isWrite = w; addr = a; wrData = d; standby = 1'b0;
    @(negedge clk);
    cycStb = 1'b0;
    lastRd = rdData;
    lastApply = modeApply;
    if (idle) standby = 1'b1;
  endtask

  task automatic progSeq(input logic [21:0] key, output logic appl);
    logic [15:0] v;
    acc(1'b0, TOP, 16'h0, 1'b1); v = lastRd;
    acc(1'b1, TOP, v, 1'b1);
    acc(1'b1, TOP, v, 1'b1);
    acc(1'b1, TOP, 16'hDEAD, 1'b1);
    acc(1'b1, TOP, 16'hBEEF, 1'b1);
    acc(1'b0, key, 16'h0, 1'b1);
    appl = lastApply;
  endtask

  task automatic powerCycle();
    @(negedge clk); powerOn = 1'b0;
    acc(1'b1, 22'h000001, 16'h9999, 1'b1);  // ignored while down
    repeat (2) @(negedge clk);
    powerOn = 1'b1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mode", 32'(pdMode), 32'd0);
    check("R1 apply", 32'(modeApply), 32'd0);
    check("R1 rdData", 32'(rdData), 32'd0);

    // Vector walk: plain traffic (R2)
    for (int i = 0; i < 12; i++) begin
      acc(VEC[i][38], VEC[i][37:16], VEC[i][15:0], 1'b1);
      if (!VEC[i][38]) check("R2 read", 32'(lastRd), 32'(VEC[i][15:0]));
    end
    topVal = 16'hA5A5;

    // R3: full pattern, 1/16 kept
    progSeq(22'h37FFFF, applied);
    check("R3 apply pulse", 32'(applied), 32'd1);
    check("R3 mode 1", 32'(pdMode), 32'd1);
    @(negedge clk);
    check("R3 pulse one cycle", 32'(modeApply), 32'd0);
    acc(1'b0, TOP, 16'h0, 1'b1);
    check("R5 dummy writes dropped", 32'(lastRd), 32'(topVal));
    progSeq(22'h27FFFF, applied);
    check("R3 mode 3", 32'(pdMode), 32'd3);

    // R4: wrong address in step 2
    acc(1'b0, TOP, 16'h0, 1'b1);
    acc(1'b1, 22'h000002, 16'h1234, 1'b1);
    acc(1'b1, TOP, topVal, 1'b1);
    acc(1'b1, TOP, topVal, 1'b1);
    acc(1'b1, TOP, topVal, 1'b1);
    acc(1'b0, 22'h2FFFFF, 16'h0, 1'b1);
    check("R4 no apply after abort", 32'(lastApply), 32'd0);
    check("R4 mode kept", 32'(pdMode), 32'd3);
    acc(1'b0, 22'h000002, 16'h0, 1'b1);
    check("R4 aborted write lands", 32'(lastRd), 32'h1234);

    // R4: wrong data in step 3
    acc(1'b0, TOP, 16'h0, 1'b1);
    acc(1'b1, TOP, topVal, 1'b1);
    acc(1'b1, TOP, 16'h5AA5, 1'b1);
    topVal = 16'h5AA5;
    acc(1'b0, TOP, 16'h0, 1'b1);
    check("R4 data mismatch write lands", 32'(lastRd), 32'(topVal));

    // R5: wrong address in step 4
    acc(1'b0, TOP, 16'h0, 1'b1); rda = lastRd;
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, 22'h000003, 16'h7777, 1'b1);
    acc(1'b0, 22'h000003, 16'h0, 1'b1);
    check("R5 stray dummy write dropped", 32'(lastRd), 32'h0033);
    check("R5 mode kept", 32'(pdMode), 32'd3);

    // R6: non-key address in step 6
    progSeq(22'h123457, applied);
    check("R6 no apply", 32'(applied), 32'd0);
    check("R6 normal read", 32'(lastRd), 32'h1111);
    check("R6 mode kept", 32'(pdMode), 32'd3);

    // R7: read of top in step 2 restarts
    acc(1'b0, TOP, 16'h0, 1'b1);
    acc(1'b0, TOP, 16'h0, 1'b1); rda = lastRd;
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, 16'h0, 1'b1);
    acc(1'b1, TOP, 16'h0, 1'b1);
    acc(1'b0, 22'h2FFFFF, 16'h0, 1'b1);
    check("R7 restart completes", 32'(lastApply), 32'd1);
    check("R7 mode 2", 32'(pdMode), 32'd2);

    // R7: write in step 6
    acc(1'b0, TOP, 16'h0, 1'b1); rda = lastRd;
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, 16'h0, 1'b1);
    acc(1'b1, TOP, 16'h0, 1'b1);
    acc(1'b1, 22'h37FFFF, 16'h5A5A, 1'b1);
    check("R7 step6 write no apply", 32'(lastApply), 32'd0);
    check("R7 mode kept", 32'(pdMode), 32'd2);
    acc(1'b0, 22'h37FFFF, 16'h0, 1'b1);
    check("R7 step6 write lands", 32'(lastRd), 32'h5A5A);

    // R8: no standby gap after step 1
    acc(1'b0, TOP, 16'h0, 1'b0); rda = lastRd;
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b1, TOP, rda, 1'b1);
    acc(1'b0, 22'h37FFFF, 16'h0, 1'b1);
    check("R8 no apply without gap", 32'(lastApply), 32'd0);
    check("R8 mode kept", 32'(pdMode), 32'd2);

    // R9: partial power-down, mode 2 keeps top bits < 2
    powerCycle();
    check("R9 mode survives", 32'(pdMode), 32'd2);
    acc(1'b0, 22'h000001, 16'h0, 1'b1);
    check("R9 kept, write ignored", 32'(lastRd), 32'h0101);
    acc(1'b0, 22'h040001, 16'h0, 1'b1);
    check("R9 kept region 1", 32'(lastRd), 32'h0202);
    acc(1'b0, 22'h000003, 16'h0, 1'b1);
    check("R9 kept low word", 32'(lastRd), 32'h0033);
    acc(1'b0, 22'h080001, 16'h0, 1'b1);
    check("R9 erased region 2", 32'(lastRd), 32'h0);
    acc(1'b0, 22'h0C0001, 16'h0, 1'b1);
    check("R9 erased region 3", 32'(lastRd), 32'h0);
    acc(1'b0, 22'h200001, 16'h0, 1'b1);
    check("R9 erased region 8", 32'(lastRd), 32'h0);

    // R9: Sleep erases all
    progSeq(TOP, applied);
    check("R3 sleep key apply", 32'(applied), 32'd1);
    check("R3 mode 0", 32'(pdMode), 32'd0);
    powerCycle();
    acc(1'b0, 22'h000001, 16'h0, 1'b1);
    check("R9 sleep erased low", 32'(lastRd), 32'h0);
    acc(1'b0, 22'h000003, 16'h0, 1'b1);
    check("R9 sleep erased word", 32'(lastRd), 32'h0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule